// File: doc/BRIEF.md
# Directory Descriptor Walk Cache

This block is a small fully associative store of first-level (directory) translation descriptors that sits beside a page-table walker. When a TLB lookup misses and a walk starts, the walker presents the virtual address together with the address-space and virtual-machine identifiers. A hit returns the cached directory descriptor one cycle later, so the walker can skip its top-level memory read. On a miss the walker fetches the descriptor itself and installs it through the fill port.

Each entry covers one 1 MB region of the 32-bit virtual space, so the tag is the upper twelve address bits, and each entry also records the ASID and VMID it was filled under. The entries are not kept coherent with the page tables in memory. Software-driven invalidation therefore exists in three flavours: every entry, every entry of one ASID, or every entry of one VMID.

Top module: `wc_walk_cache`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses, and rspValid and rspHit are low.
- R2: A lookup hits only when virtual-address bits [31:20], the ASID and the VMID all equal those of a valid entry. Address bits [19:0] play no part.
- R3: The response is registered. rspValid is high in the cycle after a cycle with lkValid high, and low otherwise. rspHit and rspDesc are valid with it, and rspDesc is zero on a miss.
- R4: A fill installs its descriptor, and a later lookup of the same region, ASID and VMID returns that descriptor.
- R5: A fill whose region, ASID and VMID match a valid entry overwrites that entry's descriptor and allocates no second entry, so no other entry is evicted.
- R6: A fill with no matching entry goes into the lowest-numbered invalid entry when one exists, and the eviction pointer is left alone.
- R7: When every entry is valid, a non-matching fill replaces the entry named by a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, on each such eviction.
- R8: An invalidate with invKind = 0 clears every entry in one cycle.
- R9: An invalidate with invKind = 1 clears exactly the entries whose ASID equals invAsid, whatever their VMID.
- R10: An invalidate with invKind = 2 clears exactly the entries whose VMID equals invVmid, whatever their ASID.
- R11: An invalidate with invKind = 3 has no effect on any entry.
- R12: A lookup in the same cycle as an invalidate sees the state after the invalidate.
- R13: A lookup in the same cycle as a fill sees the state before the fill. A fill in the same cycle as an invalidate is installed after the invalidation and survives it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lkValid | input | 1 | Lookup request strobe |
| lkVaddr | input | 32 | Lookup virtual address |
| lkAsid | input | 8 | Lookup address-space identifier |
| lkVmid | input | 8 | Lookup virtual-machine identifier |
| rspValid | output | 1 | Lookup response valid (one cycle after request) |
| rspHit | output | 1 | Lookup hit |
| rspDesc | output | 32 | Cached directory descriptor, zero on miss |
| fillValid | input | 1 | Fill request strobe |
| fillVaddr | input | 32 | Fill virtual address |
| fillAsid | input | 8 | Fill address-space identifier |
| fillVmid | input | 8 | Fill virtual-machine identifier |
| fillDesc | input | 32 | Descriptor to install |
| invValid | input | 1 | Invalidate request strobe |
| invKind | input | 2 | 0 all, 1 by ASID, 2 by VMID, 3 no operation |
| invAsid | input | 8 | ASID for invalidate-by-ASID |
| invVmid | input | 8 | VMID for invalidate-by-VMID |

## Verification
A valid bit left set wrongly shows up as a stale hit on the first lookup after an invalidate. A bit cleared wrongly shows up as a miss on an entry that should have survived. Either appears at rspHit in the cycle after that lookup. A misplaced fill or a pointer that moves when it should not evicts the wrong region, and that is caught when the bench sweeps every installed region after a full-cache or holed-cache fill sequence. A duplicate allocation also evicts an innocent entry, so it is caught the same way, and an assertion also checks that at most one entry ever matches.

// File: rtl/wc_pkg.sv
package wc_pkg;
  localparam int WC_ENTRIES = 16;
  localparam int WC_IDX_W   = $clog2(WC_ENTRIES);

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_ASID = 2'd1,
    INV_VMID = 2'd2,
    INV_NONE = 2'd3
  } invKind_e;

  // Strobes from control to datapath; one-hot entry selects.
  typedef struct packed {
    logic                  wrEn;
    logic [WC_ENTRIES-1:0] wrSel;
    logic [WC_ENTRIES-1:0] lkSel;
  } wcStrobe_t;
endpackage

// File: rtl/wc_datapath.sv
module wc_datapath
  import wc_pkg::*;
#(
  parameter int ENTRIES = WC_ENTRIES,
  parameter int TAG_W   = 12,
  parameter int ASID_W  = 8,
  parameter int VMID_W  = 8,
  parameter int DESC_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic [TAG_W-1:0]   lkTag,
  input  logic [ASID_W-1:0]  lkAsid,
  input  logic [VMID_W-1:0]  lkVmid,
  input  logic [TAG_W-1:0]   fillTag,
  input  logic [ASID_W-1:0]  fillAsid,
  input  logic [VMID_W-1:0]  fillVmid,
  input  logic [DESC_W-1:0]  fillDesc,
  input  logic [ASID_W-1:0]  invAsid,
  input  logic [VMID_W-1:0]  invVmid,
  input  wcStrobe_t          strobe,
  output logic [ENTRIES-1:0] lkMatch,
  output logic [ENTRIES-1:0] fillMatch,
  output logic [ENTRIES-1:0] asidEq,
  output logic [ENTRIES-1:0] vmidEq,
  output logic               rspValid,
  output logic               rspHit,
  output logic [DESC_W-1:0]  rspDesc
);

  logic [TAG_W-1:0]  tagQ  [ENTRIES];
  logic [ASID_W-1:0] asidQ [ENTRIES];
  logic [VMID_W-1:0] vmidQ [ENTRIES];
  logic [DESC_W-1:0] descQ [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : gEntry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        tagQ[i]  <= '0;
        asidQ[i] <= '0;
        vmidQ[i] <= '0;
        descQ[i] <= '0;
      end else if (strobe.wrEn && strobe.wrSel[i]) begin
        tagQ[i]  <= fillTag;
        asidQ[i] <= fillAsid;
        vmidQ[i] <= fillVmid;
        descQ[i] <= fillDesc;
      end
    end

    assign lkMatch[i]   = (tagQ[i] == lkTag)   && (asidQ[i] == lkAsid)   && (vmidQ[i] == lkVmid);
    assign fillMatch[i] = (tagQ[i] == fillTag) && (asidQ[i] == fillAsid) && (vmidQ[i] == fillVmid);
    assign asidEq[i]    = (asidQ[i] == invAsid);
    assign vmidEq[i]    = (vmidQ[i] == invVmid);
  end

  logic [DESC_W-1:0] selDesc;
  always_comb begin
    selDesc = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (strobe.lkSel[i]) selDesc = selDesc | descQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
      rspDesc  <= '0;
    end else begin
      rspValid <= lkValid;
      rspHit   <= lkValid && (|strobe.lkSel);
      rspDesc  <= lkValid ? selDesc : '0;
    end
  end

  // R3: response follows the request by exactly one cycle
  assert_rsp_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  assert_rsp_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> (!rspValid && !rspHit));
  // R3: a miss carries a zero descriptor
  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspDesc == '0));

endmodule

// File: rtl/wc_ctrl.sv
module wc_ctrl
  import wc_pkg::*;
#(
  parameter int ENTRIES = WC_ENTRIES,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkValid,
  input  logic               fillValid,
  input  logic               invValid,
  input  invKind_e           invKind,
  input  logic [ENTRIES-1:0] lkMatch,
  input  logic [ENTRIES-1:0] fillMatch,
  input  logic [ENTRIES-1:0] asidEq,
  input  logic [ENTRIES-1:0] vmidEq,
  output wcStrobe_t          strobe
);

  logic [ENTRIES-1:0] validQ;
  logic [IDX_W-1:0]   victimQ;

  logic [ENTRIES-1:0] invMask;
  logic [ENTRIES-1:0] validPost;
  logic [ENTRIES-1:0] fillHitVec;
  logic [ENTRIES-1:0] freeVec;
  logic [ENTRIES-1:0] firstFree;
  logic [ENTRIES-1:0] victimOneHot;
  logic [ENTRIES-1:0] wrSel;
  logic               useVictim;
  logic [IDX_W-1:0]   victimNext;

  always_comb begin
    invMask = '0;
    if (invValid) begin
      case (invKind)
        INV_ALL:  invMask = '1;
        INV_ASID: invMask = asidEq;
        INV_VMID: invMask = vmidEq;
        default:  invMask = '0;
      endcase
    end
  end

  // Invalidation is applied before lookup and before fill placement.
  assign validPost    = validQ & ~invMask;
  assign fillHitVec   = validPost & fillMatch;
  assign freeVec      = ~validPost;
  assign firstFree    = freeVec & (~freeVec + ENTRIES'(1));
  assign victimOneHot = ENTRIES'(1) << victimQ;

  always_comb begin
    wrSel     = '0;
    useVictim = 1'b0;
    if (fillValid) begin
      if (|fillHitVec) begin
        wrSel = fillHitVec;
      end else if (|freeVec) begin
        wrSel = firstFree;
      end else begin
        wrSel     = victimOneHot;
        useVictim = 1'b1;
      end
    end
  end

  assign victimNext = (victimQ == IDX_W'(ENTRIES - 1)) ? '0 : victimQ + IDX_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ  <= '0;
      victimQ <= '0;
    end else begin
      validQ <= validPost | wrSel;
      if (useVictim) victimQ <= victimNext;
    end
  end

  assign strobe.wrEn  = fillValid;
  assign strobe.wrSel = wrSel;
  assign strobe.lkSel = lkValid ? (validPost & lkMatch) : '0;

  // R1: reset empties the cache
  assert_reset_empty_R1: assert property (@(posedge clk)
    !rstN |=> (validQ == '0));
  // R5: never more than one valid entry matches a request
  assert_single_match_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(validQ & lkMatch) && $onehot0(validQ & fillMatch));
  // R4: a fill leaves at least one valid entry
  assert_fill_installs_R4: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> ($countones(validQ) >= 1));
  // R8: flush-all with no concurrent fill empties the cache
  assert_flush_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && invKind == INV_ALL && !fillValid) |=> (validQ == '0));
  // R7: pointer moves on an eviction and only then
  assert_victim_moves_R7: assert property (@(posedge clk) disable iff (!rstN)
    useVictim |=> (victimQ != $past(victimQ)));
  assert_victim_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    !useVictim |=> $stable(victimQ));
  // R6: an eviction happens only with every entry valid
  assert_evict_full_R6: assert property (@(posedge clk) disable iff (!rstN)
    useVictim |-> (validPost == '1));

endmodule

// File: rtl/wc_walk_cache.sv
module wc_walk_cache
  import wc_pkg::*;
#(
  parameter int ENTRIES    = WC_ENTRIES,
  parameter int VA_W       = 32,
  parameter int REGION_LSB = 20,
  parameter int ASID_W     = 8,
  parameter int VMID_W     = 8,
  parameter int DESC_W     = 32,
  localparam int TAG_W     = VA_W - REGION_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [VA_W-1:0]   lkVaddr,
  input  logic [ASID_W-1:0] lkAsid,
  input  logic [VMID_W-1:0] lkVmid,
  output logic              rspValid,
  output logic              rspHit,
  output logic [DESC_W-1:0] rspDesc,
  input  logic              fillValid,
  input  logic [VA_W-1:0]   fillVaddr,
  input  logic [ASID_W-1:0] fillAsid,
  input  logic [VMID_W-1:0] fillVmid,
  input  logic [DESC_W-1:0] fillDesc,
  input  logic              invValid,
  input  logic [1:0]        invKind,
  input  logic [ASID_W-1:0] invAsid,
  input  logic [VMID_W-1:0] invVmid
);

  wcStrobe_t          strobe;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] fillMatch;
  logic [ENTRIES-1:0] asidEq;
  logic [ENTRIES-1:0] vmidEq;

  logic unusedLowBits;
  assign unusedLowBits = ^{lkVaddr[REGION_LSB-1:0], fillVaddr[REGION_LSB-1:0]};

  wc_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .lkValid   (lkValid),
    .fillValid (fillValid),
    .invValid  (invValid),
    .invKind   (invKind_e'(invKind)),
    .lkMatch   (lkMatch),
    .fillMatch (fillMatch),
    .asidEq    (asidEq),
    .vmidEq    (vmidEq),
    .strobe    (strobe)
  );

  wc_datapath #(
    .ENTRIES (ENTRIES),
    .TAG_W   (TAG_W),
    .ASID_W  (ASID_W),
    .VMID_W  (VMID_W),
    .DESC_W  (DESC_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .lkValid   (lkValid),
    .lkTag     (lkVaddr[VA_W-1:REGION_LSB]),
    .lkAsid    (lkAsid),
    .lkVmid    (lkVmid),
    .fillTag   (fillVaddr[VA_W-1:REGION_LSB]),
    .fillAsid  (fillAsid),
    .fillVmid  (fillVmid),
    .fillDesc  (fillDesc),
    .invAsid   (invAsid),
    .invVmid   (invVmid),
    .strobe    (strobe),
    .lkMatch   (lkMatch),
    .fillMatch (fillMatch),
    .asidEq    (asidEq),
    .vmidEq    (vmidEq),
    .rspValid  (rspValid),
    .rspHit    (rspHit),
    .rspDesc   (rspDesc)
  );

  // R12: a lookup beside a flush-all cannot hit
  assert_flush_beats_lookup_R12: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && invValid && invKind == 2'd0) |=> !rspHit);

endmodule

// File: tb/wc_walk_cache_test.sv
module wc_walk_cache_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic [31:0] lkVaddr = '0;
  logic [7:0]  lkAsid = '0;
  logic [7:0]  lkVmid = '0;
  logic        rspValid;
  logic        rspHit;
  logic [31:0] rspDesc;
  logic        fillValid = 1'b0;
  logic [31:0] fillVaddr = '0;
  logic [7:0]  fillAsid = '0;
  logic [7:0]  fillVmid = '0;
  logic [31:0] fillDesc = '0;
  logic        invValid = 1'b0;
  logic [1:0]  invKind = '0;
  logic [7:0]  invAsid = '0;
  logic [7:0]  invVmid = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wc_walk_cache uut (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkVaddr(lkVaddr), .lkAsid(lkAsid), .lkVmid(lkVmid),
    .rspValid(rspValid), .rspHit(rspHit), .rspDesc(rspDesc),
    .fillValid(fillValid), .fillVaddr(fillVaddr), .fillAsid(fillAsid),
    .fillVmid(fillVmid), .fillDesc(fillDesc),
    .invValid(invValid), .invKind(invKind), .invAsid(invAsid), .invVmid(invVmid)
  );

  function automatic logic [31:0] rva(int region, int off);
    return {region[11:0], off[19:0]};
  endfunction

  function automatic logic [31:0] dsc(int region);
    return 32'hD000_0000 | region;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic look(string req, int region, int off, int asid, int vmid,
                      bit expHit, logic [31:0] expDesc);
    @(negedge clk);
    lkValid = 1'b1; lkVaddr = rva(region, off);
    lkAsid = asid[7:0]; lkVmid = vmid[7:0];
    @(negedge clk);
    lkValid = 1'b0;
    chk({req, " rspValid"}, rspValid, 1);
    chk({req, " rspHit"}, rspHit, expHit);
    chk({req, " rspDesc"}, rspDesc, expHit ? expDesc : 32'h0);
  endtask

  task automatic fill(int region, int asid, int vmid, logic [31:0] d);
    @(negedge clk);
    fillValid = 1'b1; fillVaddr = rva(region, 32'h123);
    fillAsid = asid[7:0]; fillVmid = vmid[7:0]; fillDesc = d;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic inval(int kind, int asid, int vmid);
    @(negedge clk);
    invValid = 1'b1; invKind = kind[1:0];
    invAsid = asid[7:0]; invVmid = vmid[7:0];
    @(negedge clk);
    invValid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rspValid after reset", rspValid, 0);
    chk("R1 rspHit after reset", rspHit, 0);
    look("R1 empty lookup", 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R3 rspValid low without request", rspValid, 0);
  endtask

  task automatic t_fillHit;
    fill(5, 1, 2, dsc(5));
    look("R4 hit after fill", 5, 32'hABCDE, 1, 2, 1, dsc(5));
    look("R2 other offset hits", 5, 0, 1, 2, 1, dsc(5));
    look("R2 asid mismatch", 5, 0, 3, 2, 0, 0);
    look("R2 vmid mismatch", 5, 0, 1, 3, 0, 0);
    look("R2 region mismatch", 6, 0, 1, 2, 0, 0);
  endtask

  task automatic t_concurrentFill;
    @(negedge clk);
    fillValid = 1'b1; fillVaddr = rva(60, 0); fillAsid = 8'd1; fillVmid = 8'd1;
    fillDesc = dsc(60);
    lkValid = 1'b1; lkVaddr = rva(60, 0); lkAsid = 8'd1; lkVmid = 8'd1;
    @(negedge clk);
    fillValid = 1'b0; lkValid = 1'b0;
    chk("R13 lookup beside fill misses", rspHit, 0);
    look("R13 hit after concurrent fill", 60, 7, 1, 1, 1, dsc(60));
  endtask

  task automatic t_invAll;
    fill(7, 2, 2, dsc(7));
    inval(0, 0, 0);
    look("R8 flushed region 5", 5, 0, 1, 2, 0, 0);
    look("R8 flushed region 7", 7, 0, 2, 2, 0, 0);
    look("R8 flushed region 60", 60, 0, 1, 1, 0, 0);
    // fill and flush-all in the same cycle: the fill survives
    @(negedge clk);
    fillValid = 1'b1; fillVaddr = rva(61, 0); fillAsid = 8'd1; fillVmid = 8'd1;
    fillDesc = dsc(61);
    invValid = 1'b1; invKind = 2'd0;
    @(negedge clk);
    fillValid = 1'b0; invValid = 1'b0;
    look("R13 fill survives same-cycle flush", 61, 0, 1, 1, 1, dsc(61));
    inval(0, 0, 0);
  endtask

  task automatic t_replace;
    for (int i = 0; i < 16; i++) fill(i, 1, 1, dsc(i));
    fill(3, 1, 1, 32'hCAFE_0003);
    look("R5 overwritten descriptor", 3, 0, 1, 1, 1, 32'hCAFE_0003);
    for (int i = 0; i < 16; i++)
      if (i != 3) look("R5 no entry evicted by refill", i, 0, 1, 1, 1, dsc(i));
    fill(16, 1, 1, dsc(16));
    look("R7 first eviction takes entry 0", 0, 0, 1, 1, 0, 0);
    look("R7 new region present", 16, 0, 1, 1, 1, dsc(16));
    fill(17, 1, 1, dsc(17));
    look("R7 second eviction takes entry 1", 1, 0, 1, 1, 0, 0);
    look("R7 entry 2 kept", 2, 0, 1, 1, 1, dsc(2));
    look("R7 second new region present", 17, 0, 1, 1, 1, dsc(17));
  endtask

  task automatic t_firstFree;
    inval(0, 0, 0);
    for (int i = 0; i < 16; i++) fill(i, (i == 4 || i == 9) ? 2 : 1, 1, dsc(i));
    inval(1, 2, 0);
    look("R9 asid-2 entry 4 cleared", 4, 0, 2, 1, 0, 0);
    look("R9 asid-2 entry 9 cleared", 9, 0, 2, 1, 0, 0);
    fill(20, 1, 1, dsc(20));
    fill(21, 1, 1, dsc(21));
    for (int i = 0; i < 16; i++)
      if (i != 4 && i != 9) look("R6 holes reused, nothing evicted", i, 0, 1, 1, 1, dsc(i));
    look("R6 region 20 installed", 20, 0, 1, 1, 1, dsc(20));
    look("R6 region 21 installed", 21, 0, 1, 1, 1, dsc(21));
  endtask

  task automatic setupMix;
    inval(0, 0, 0);
    fill(40, 5, 1, dsc(40));
    fill(41, 5, 2, dsc(41));
    fill(42, 6, 1, dsc(42));
    fill(43, 6, 2, dsc(43));
  endtask

  task automatic t_invAsid;
    setupMix();
    inval(1, 5, 0);
    look("R9 asid 5 vmid 1 cleared", 40, 0, 5, 1, 0, 0);
    look("R9 asid 5 vmid 2 cleared", 41, 0, 5, 2, 0, 0);
    look("R9 asid 6 vmid 1 kept", 42, 0, 6, 1, 1, dsc(42));
    look("R9 asid 6 vmid 2 kept", 43, 0, 6, 2, 1, dsc(43));
  endtask

  task automatic t_invVmid;
    setupMix();
    inval(2, 0, 2);
    look("R10 asid 5 vmid 1 kept", 40, 0, 5, 1, 1, dsc(40));
    look("R10 asid 5 vmid 2 cleared", 41, 0, 5, 2, 0, 0);
    look("R10 asid 6 vmid 1 kept", 42, 0, 6, 1, 1, dsc(42));
    look("R10 asid 6 vmid 2 cleared", 43, 0, 6, 2, 0, 0);
  endtask

  task automatic t_invNone;
    setupMix();
    inval(3, 5, 1);
    look("R11 entry 40 kept", 40, 0, 5, 1, 1, dsc(40));
    look("R11 entry 41 kept", 41, 0, 5, 2, 1, dsc(41));
    look("R11 entry 42 kept", 42, 0, 6, 1, 1, dsc(42));
    look("R11 entry 43 kept", 43, 0, 6, 2, 1, dsc(43));
  endtask

  task automatic t_invLookup;
    setupMix();
    @(negedge clk);
    invValid = 1'b1; invKind = 2'd1; invAsid = 8'd6;
    lkValid = 1'b1; lkVaddr = rva(40, 0); lkAsid = 8'd5; lkVmid = 8'd1;
    @(negedge clk);
    invValid = 1'b0; lkValid = 1'b0;
    chk("R12 untouched entry hits beside invalidate", rspHit, 1);
    chk("R12 untouched descriptor", rspDesc, dsc(40));
    @(negedge clk);
    invValid = 1'b1; invKind = 2'd0;
    lkValid = 1'b1; lkVaddr = rva(40, 0); lkAsid = 8'd5; lkVmid = 8'd1;
    @(negedge clk);
    invValid = 1'b0; lkValid = 1'b0;
    chk("R12 lookup beside flush-all misses", rspHit, 0);
    chk("R12 descriptor zero beside flush", rspDesc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fillHit();
    t_concurrentFill();
    t_invAll();
    t_replace();
    t_firstFree();
    t_invAsid();
    t_invVmid();
    t_invNone();
    t_invLookup();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1..R13 run actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule